// File: doc/BRIEF.md
# Store Data and Byte-Enable Generator

This block sits between a processor's execute stage and a 32-bit word-wide data memory port. For every store request it adds the sign-extended 16-bit displacement to the base register value to form the effective address. It moves the source register bytes into the memory byte lanes that the store targets. It also produces the byte-enable mask for those lanes. Five store kinds are supported: byte, halfword, full word, and the two partial-word stores (left and right) used to write an unaligned word in two steps.

Byte order is big-endian: byte offset 0 within a word is the most significant lane, bits [31:24], and byte-enable bit 3 belongs to it. All results are registered, so they appear one clock after the request together with a single-cycle write strobe. A halfword or word store whose address is not naturally aligned is not issued. Instead it raises an address-error flag for one cycle, with all byte enables at zero.

Top module: `store_lane_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `wrStrobe`, `addrErr` and `byteEn` are all zero.
- R2: The effective address is `baseVal` plus `offset` sign-extended to 32 bits. Whenever `wrStrobe` or `addrErr` is high, `wrAddr` equals that address with bits [1:0] cleared.
- R3: A byte store (`opCode` 0) at byte offset k enables only byte-enable bit 3-k and places `srcVal[7:0]` in that lane.
- R4: A halfword store (`opCode` 1) at offset 0 enables bits 3 and 2 with `srcVal[15:0]` in bits [31:16]. At offset 2 it enables bits 1 and 0 with `srcVal[15:0]` in bits [15:0].
- R5: A word store (`opCode` 2) at offset 0 enables all four lanes and writes `srcVal` unchanged.
- R6: A left partial store (`opCode` 3) at offset k enables bits (3-k) down to 0. Its data is `srcVal` shifted right by 8*k, so the most significant source byte lands in the addressed lane.
- R7: A right partial store (`opCode` 4) at offset k enables bits 3 down to (3-k). Its data is `srcVal` shifted left by 8*(3-k), so the least significant source byte lands in the addressed lane.
- R8: A halfword store with address bit 0 set, or a word store with address bits [1:0] nonzero, raises `addrErr` for one cycle with `wrStrobe` low and `byteEn` zero.
- R9: `wrStrobe` is high for exactly one cycle, the cycle after each accepted store request. With `reqValid` low, or with an unused `opCode` (5 to 7), neither `wrStrobe` nor `addrErr` rises and `byteEn` is zero.
- R10: During a write strobe, every `wrData` byte whose lane is disabled is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request present this cycle |
| opCode | input | 3 | Store kind: 0 byte, 1 halfword, 2 word, 3 left partial, 4 right partial |
| offset | input | 16 | Signed address displacement |
| baseVal | input | 32 | Base register value |
| srcVal | input | 32 | Source register value to be stored |
| wrStrobe | output | 1 | One-cycle write strobe |
| wrAddr | output | 32 | Word-aligned write address |
| wrData | output | 32 | Lane-aligned write data |
| byteEn | output | 4 | Byte enables, bit 3 = byte offset 0 |
| addrErr | output | 1 | Misaligned store flag |

## Verification
Every output of the block is due at the first rising edge after the request is presented. None is due combinationally, and none arrives later. The bench drives a new request, or an idle cycle, on each falling edge. At the next falling edge it compares the outputs against the expectation computed for the previous cycle's inputs, so back-to-back requests are checked without gaps. `wrData` is compared only in strobe cycles. `wrAddr` is compared only when a strobe or an error is reported.

// File: rtl/slg_pkg.sv
package slg_pkg;

  typedef enum logic [2:0] {
    OP_BYTE  = 3'd0,
    OP_HALF  = 3'd1,
    OP_WORD  = 3'd2,
    OP_LEFT  = 3'd3,
    OP_RIGHT = 3'd4
  } slg_op_e;

  localparam logic [2:0] OP_LAST = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic    issue;
    logic    fault;
    slg_op_e kind;
  } slg_ctl_t;

endpackage

// File: rtl/slg_ctrl.sv
module slg_ctrl
  import slg_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 reqValid,
  input  logic [2:0]           opCode,
  input  logic [LANE_BITS-1:0] addrLow,
  output slg_ctl_t             ctl
);

  logic legalOp;
  logic misaligned;

  always_comb begin
    legalOp = (opCode <= OP_LAST);
    unique case (opCode)
      OP_HALF: misaligned = addrLow[0];
      OP_WORD: misaligned = |addrLow;
      default: misaligned = 1'b0;
    endcase
    ctl.kind  = slg_op_e'(opCode);
    ctl.issue = reqValid && legalOp && !misaligned;
    ctl.fault = reqValid && legalOp && misaligned;
  end

endmodule

// File: rtl/slg_datapath.sv
module slg_datapath
  import slg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFF_W-1:0]     offset,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [DATA_W-1:0]    srcVal,
  input  slg_ctl_t             ctl,
  output logic [LANE_BITS-1:0] addrLow,
  output logic                 wrStrobe,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic [LANES-1:0]     byteEn,
  output logic                 addrErr
);

  localparam logic [LANES-1:0] ALL_EN = '1;
  localparam logic [LANE_BITS-1:0] TOP_LANE = LANE_BITS'(LANES - 1);

  logic [ADDR_W-1:0]    effAddr;
  logic [LANE_BITS-1:0] laneSh;
  logic [LANE_BITS-1:0] halfSh;
  logic [LANES-1:0]     nextEn;
  logic [DATA_W-1:0]    nextData;

  assign effAddr = baseVal + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign addrLow = effAddr[LANE_BITS-1:0];
  assign laneSh  = TOP_LANE - addrLow;
  assign halfSh  = laneSh - LANE_BITS'(1);

  always_comb begin
    nextEn   = '0;
    nextData = '0;
    unique case (ctl.kind)
      OP_BYTE: begin
        nextEn   = LANES'(1) << laneSh;
        nextData = DATA_W'(srcVal[7:0]) << {laneSh, 3'b000};
      end
      OP_HALF: begin
        nextEn   = LANES'(3) << halfSh;
        nextData = DATA_W'(srcVal[15:0]) << {halfSh, 3'b000};
      end
      OP_WORD: begin
        nextEn   = ALL_EN;
        nextData = srcVal;
      end
      OP_LEFT: begin
        nextEn   = ALL_EN >> addrLow;
        nextData = srcVal >> {addrLow, 3'b000};
      end
      OP_RIGHT: begin
        nextEn   = ALL_EN << laneSh;
        nextData = srcVal << {laneSh, 3'b000};
      end
      default: begin
        nextEn   = '0;
        nextData = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      addrErr  <= 1'b0;
      byteEn   <= '0;
      wrAddr   <= '0;
    end else begin
      wrStrobe <= ctl.issue;
      addrErr  <= ctl.fault;
      byteEn   <= ctl.issue ? nextEn : '0;
      if (ctl.issue || ctl.fault)
        wrAddr <= {effAddr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
    end
  end

  // Per-lane data registers and the lane mask used by the checks
  logic [DATA_W-1:0] enMask;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign enMask[8*g +: 8] = {8{byteEn[g]}};
    always_ff @(posedge clk) begin
      if (!rstN)
        wrData[8*g +: 8] <= '0;
      else if (ctl.issue)
        wrData[8*g +: 8] <= nextData[8*g +: 8];
    end
  end

  a_r8_err_excludes_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && addrErr));

  a_r9_enables_need_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> (byteEn == '0));

  a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe || addrErr) |-> (wrAddr[LANE_BITS-1:0] == '0));

  a_r10_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ((wrData & ~enMask) == '0));

  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && $past(ctl.kind == OP_BYTE)) |-> ($countones(byteEn) == 1));

  a_r4_two_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && $past(ctl.kind == OP_HALF)) |-> ($countones(byteEn) == 2));

endmodule

// File: rtl/store_lane_gen.sv
module store_lane_gen
  import slg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        opCode,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [DATA_W-1:0] srcVal,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  byteEn,
  output logic              addrErr
);

  slg_ctl_t             ctl;
  logic [LANE_BITS-1:0] addrLow;

  slg_ctrl #(.LANE_BITS(LANE_BITS)) u_ctrl (
    .reqValid (reqValid),
    .opCode   (opCode),
    .addrLow  (addrLow),
    .ctl      (ctl)
  );

  slg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .offset   (offset),
    .baseVal  (baseVal),
    .srcVal   (srcVal),
    .ctl      (ctl),
    .addrLow  (addrLow),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .byteEn   (byteEn),
    .addrErr  (addrErr)
  );

  a_r9_strobe_after_request: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe || addrErr) |-> $past(reqValid && (opCode <= OP_LAST)));

endmodule

// File: tb/store_lane_gen_tb.sv
module store_lane_gen_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  opCode;
  logic [15:0] offset;
  logic [31:0] baseVal;
  logic [31:0] srcVal;
  logic        wrStrobe;
  logic [31:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0]  byteEn;
  logic        addrErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  store_lane_gen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opCode),
    .offset(offset), .baseVal(baseVal), .srcVal(srcVal),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .byteEn(byteEn), .addrErr(addrErr)
  );

  // Expected results for the request driven in the previous cycle
  logic        expStrobe, expErr;
  logic [3:0]  expEn;
  logic [31:0] expData, expAddr;
  string       expTag;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string opTag(logic [2:0] op);
    case (op)
      3'd0: return "R3 byte";
      3'd1: return "R4 half";
      3'd2: return "R5 word";
      3'd3: return "R6 left";
      3'd4: return "R7 right";
      default: return "R9 unused";
    endcase
  endfunction

  // Reference model, big-endian lanes, byte offset j lives in bits [31-8j -: 8]
  task automatic predict(logic v, logic [2:0] op, logic [15:0] off,
                         logic [31:0] base, logic [31:0] src);
    logic [31:0] ea;
    int k;
    logic bad;
    ea = base + {{16{off[15]}}, off};
    k  = int'(ea[1:0]);
    expAddr = {ea[31:2], 2'b00};
    expEn   = '0;
    expData = '0;
    expTag  = opTag(op);
    bad     = (op == 3'd1 && ea[0]) || (op == 3'd2 && k != 0);
    expErr    = v && op <= 3'd4 && bad;
    expStrobe = v && op <= 3'd4 && !bad;
    if (expStrobe) begin
      for (int j = 0; j < 4; j++) begin
        logic on;
        logic [7:0] b;
        on = 1'b0;
        b  = 8'h00;
        case (op)
          3'd0: if (j == k) begin on = 1; b = src[7:0]; end
          3'd1: begin
            if (j == k)     begin on = 1; b = src[15:8]; end
            if (j == k + 1) begin on = 1; b = src[7:0];  end
          end
          3'd2: begin on = 1; b = src[31-8*j -: 8]; end
          3'd3: if (j >= k) begin on = 1; b = src[31-8*(j-k) -: 8]; end
          3'd4: if (j <= k) begin on = 1; b = src[8*(k-j) +: 8]; end
          default: ;
        endcase
        expEn[3-j] = on;
        expData[31-8*j -: 8] = b;
      end
    end
  endtask

  task automatic compareOutputs();
    check("R9 strobe", 32'(wrStrobe), 32'(expStrobe));
    check("R8 addrErr", 32'(addrErr), 32'(expErr));
    check({expTag, " byteEn (R8/R9 when not issued)"}, 32'(byteEn), 32'(expEn));
    if (expStrobe)
      check({expTag, " wrData (R10 idle lanes zero)"}, wrData, expData);
    if (expStrobe || expErr)
      check("R2 wrAddr", wrAddr, expAddr);
  endtask

  // One cycle: check the previous request's results, then drive the next
  task automatic step(logic v, logic [2:0] op, logic [15:0] off,
                      logic [31:0] base, logic [31:0] src);
    @(negedge clk);
    compareOutputs();
    reqValid = v; opCode = op; offset = off; baseVal = base; srcVal = src;
    predict(v, op, off, base, src);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; opCode = '0; offset = '0;
    baseVal = '0; srcVal = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 strobe in reset", 32'(wrStrobe), 32'd0);
    check("R1 addrErr in reset", 32'(addrErr), 32'd0);
    check("R1 byteEn in reset", 32'(byteEn), 32'd0);
    rstN = 1'b1;
    predict(1'b0, 3'd0, '0, '0, '0);

    // Directed: every kind at every byte offset, positive base
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 4; k++)
        step(1'b1, 3'(op), 16'd8, 32'h0000_1000 + 32'(k), 32'h1122_3344);
    // R2: negative displacement crossing a word boundary
    step(1'b1, 3'd2, 16'hFFFC, 32'h0000_2000, 32'hA5A5_0F0F);
    step(1'b1, 3'd3, 16'hFFFF, 32'h0000_2000, 32'hDEAD_BEEF);
    step(1'b1, 3'd4, 16'h8000, 32'h0001_0003, 32'hCAFE_F00D);
    // R9: idle with a valid-looking op on the bus
    step(1'b0, 3'd2, 16'd0, 32'h0000_0100, 32'hFFFF_FFFF);
    step(1'b0, 3'd0, 16'd1, 32'h0000_0100, 32'hFFFF_FFFF);

    // Constrained random, mostly legal ops, about 80% requests
    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [2:0] op;
      v  = ($urandom_range(0, 9) < 8);
      op = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7))
                                       : 3'($urandom_range(0, 4));
      step(v, op, 16'($urandom), $urandom, $urandom);
    end
    step(1'b0, 3'd0, '0, '0, '0);
    @(negedge clk);
    compareOutputs();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule